// File: doc/BRIEF.md
# Bit-Serial Compare-Exchange Cell

This cell takes two unsigned numbers that arrive one bit per clock, most significant bit first, and sends them back out bit-serially in order. The smaller number leaves on the low output and the larger on the high output. A `start` pulse, given with the first bit of each word pair, tells the cell that a new comparison begins. The cell compares the two streams as they arrive. Up to the first bit where they differ, both outputs repeat the common bit. From the first differing bit onward, the cell fixes its routing and keeps it until the next `start`.

A second, reverse path sends two return signals back through the cell. They are steered by the same routing decision, so a chain of cells can carry replies from its outputs back to its inputs. A parameter adds one register stage on the forward outputs. This re-clocks the data at each cell of a network. The reverse path stays combinational.

Routing encoding used throughout:

| Value | Meaning |
|-------|---------|
| 0 | equal so far |
| 1 | A greater |
| 2 | A less |

Top module: `serial_minmax_cell`

## Requirements
- R1: A bit presented with `start` high is compared as the first bit of a new word pair. Routing kept from the previous pair is discarded for that bit.
- R2: While routing is "equal so far", both `lo_bit` and `hi_bit` carry the current `a_bit`.
- R3: The first bit of a pair with `a_bit`=1 and `b_bit`=0 sets routing to "A greater". The first bit with `a_bit`=0 and `b_bit`=1 sets it to "A less". The new routing already steers that same bit.
- R4: Once set to "A greater" or "A less", routing is kept for every following bit, whatever their values, until the next `start` or reset.
- R5: Under "A greater", `hi_bit` carries A and `lo_bit` carries B. Under "A less", `hi_bit` carries B and `lo_bit` carries A. As a result, the collected low word equals min(A,B) and the collected high word equals max(A,B).
- R6: Under "A greater", `rev_a_out`=`rev_hi_in` and `rev_b_out`=`rev_lo_in`. Under "A less", `rev_b_out`=`rev_hi_in` and `rev_a_out`=`rev_lo_in`. The reverse path is combinational.
- R7: Under "equal so far", `rev_a_out`=`rev_lo_in` and `rev_b_out`=`rev_hi_in`.
- R8: With `OUT_REG`=1, `lo_bit` and `hi_bit` show the steered bits one clock after the inputs are presented.
- R9: An asynchronous low `rst_n` clears both forward outputs to 0 and sets routing to "equal so far", so a later bit is compared fresh even without `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Marks the first bit of a new word pair |
| a_bit | input | 1 | Serial operand A, MSB first |
| b_bit | input | 1 | Serial operand B, MSB first |
| lo_bit | output | 1 | Serial minimum |
| hi_bit | output | 1 | Serial maximum |
| rev_hi_in | input | 1 | Return signal entering at the high side |
| rev_lo_in | input | 1 | Return signal entering at the low side |
| rev_a_out | output | 1 | Return signal leaving at the A side |
| rev_b_out | output | 1 | Return signal leaving at the B side |

## Verification
The reverse outputs depend on the routing chosen for the bit now presented. The bench therefore checks them one time unit after it drives each bit, within the same clock period. The forward outputs pass through one register, so the result for bit i is read at the falling edge after the rising edge that captures bit i. This is the same falling edge at which bit i+1 is driven, and the bench reads the outputs before it changes any input. The word-level results (min and max) are complete one clock after the last bit. The reset check reads the outputs during reset, and then reads the first result one clock after a bit is driven without `start`.

// File: rtl/serial_minmax_cell.sv
`timescale 1ns/1ps
module serial_minmax_cell #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic a_bit,
  input  logic b_bit,
  output logic lo_bit,
  output logic hi_bit,
  input  logic rev_hi_in,
  input  logic rev_lo_in,
  output logic rev_a_out,
  output logic rev_b_out
);
  localparam logic [1:0] ST_EQ  = 2'd0;
  localparam logic [1:0] ST_AGT = 2'd1;
  localparam logic [1:0] ST_ALT = 2'd2;

  logic [1:0] state_q, base, route;
  logic       lo_c, hi_c;

  assign base = start ? ST_EQ : state_q;

  always_comb begin
    route = base;
    if (base == ST_EQ) begin
      if (a_bit && !b_bit)      route = ST_AGT;
      else if (!a_bit && b_bit) route = ST_ALT;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= ST_EQ;
    else        state_q <= route;

  assign hi_c = (route == ST_ALT) ? b_bit : a_bit;
  assign lo_c = (route == ST_AGT) ? b_bit : a_bit;

  assign rev_a_out = (route == ST_AGT) ? rev_hi_in : rev_lo_in;
  assign rev_b_out = (route == ST_AGT) ? rev_lo_in : rev_hi_in;

  generate
    if (OUT_REG) begin : g_reg
      logic lo_q, hi_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          lo_q <= 1'b0;
          hi_q <= 1'b0;
        end else begin
          lo_q <= lo_c;
          hi_q <= hi_c;
        end
      assign lo_bit = lo_q;
      assign hi_bit = hi_q;
    end else begin : g_comb
      assign lo_bit = lo_c;
      assign hi_bit = hi_c;
    end
  endgenerate
endmodule

// File: rtl/serial_minmax_cell_chk.sv
`timescale 1ns/1ps
module serial_minmax_cell_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       a_bit,
  input logic       b_bit,
  input logic       lo_bit,
  input logic       hi_bit,
  input logic       rev_hi_in,
  input logic       rev_lo_in,
  input logic       rev_a_out,
  input logic       rev_b_out,
  input logic [1:0] cur,
  input logic [1:0] route
);
  p_fresh_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (a_bit == b_bit)) |-> (route == 2'd0));

  p_decide_gt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((start || cur == 2'd0) && a_bit && !b_bit) |=> (cur == 2'd1));

  p_decide_lt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((start || cur == 2'd0) && !a_bit && b_bit) |=> (cur == 2'd2));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cur != 2'd0) |=> (cur == $past(cur)));

  p_rev_gt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (route == 2'd1) |-> (rev_a_out == rev_hi_in && rev_b_out == rev_lo_in));

  p_rev_lt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (route == 2'd2) |-> (rev_b_out == rev_hi_in && rev_a_out == rev_lo_in));

  p_rev_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (route == 2'd0) |-> (rev_a_out == rev_lo_in && rev_b_out == rev_hi_in));

  generate
    if (OUT_REG) begin : g_lag
      p_equal_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (route == 2'd0) |=> (lo_bit == $past(a_bit) && hi_bit == $past(a_bit)));
      p_order_gt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (route == 2'd1) |=> (hi_bit == $past(a_bit) && lo_bit == $past(b_bit)));
      p_order_lt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (route == 2'd2) |=> (hi_bit == $past(b_bit) && lo_bit == $past(a_bit)));
    end else begin : g_now
      p_equal_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (route == 2'd0) |-> (lo_bit == a_bit && hi_bit == a_bit));
      p_order_gt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (route == 2'd1) |-> (hi_bit == a_bit && lo_bit == b_bit));
      p_order_lt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (route == 2'd2) |-> (hi_bit == b_bit && lo_bit == a_bit));
    end
  endgenerate
endmodule

bind serial_minmax_cell serial_minmax_cell_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .a_bit(a_bit), .b_bit(b_bit),
  .lo_bit(lo_bit), .hi_bit(hi_bit), .rev_hi_in(rev_hi_in), .rev_lo_in(rev_lo_in),
  .rev_a_out(rev_a_out), .rev_b_out(rev_b_out), .cur(state_q), .route(route)
);

// File: tb/serial_minmax_cell_test.sv
`timescale 1ns/1ps
module serial_minmax_cell_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, a_bit, b_bit, rev_hi_in, rev_lo_in;
  logic lo_bit, hi_bit, rev_a_out, rev_b_out;
  int errs = 0, checks = 0;
  bit done = 0;

  serial_minmax_cell #(.OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_bit(a_bit), .b_bit(b_bit),
    .lo_bit(lo_bit), .hi_bit(hi_bit), .rev_hi_in(rev_hi_in), .rev_lo_in(rev_lo_in),
    .rev_a_out(rev_a_out), .rev_b_out(rev_b_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Streams np word pairs back to back; checks min/max words and reverse path.
  task automatic stream(input logic [W-1:0] a0, input logic [W-1:0] b0,
                        input logic [W-1:0] a1, input logic [W-1:0] b1,
                        input int np, input string tag);
    logic [W-1:0] lo_w [2];
    logic [W-1:0] hi_w [2];
    int rev_bad [2];
    int st;
    logic [W-1:0] aw, bw;
    rev_bad[0] = 0; rev_bad[1] = 0; st = 0;
    for (int i = 0; i <= np*W; i++) begin
      @(negedge clk);
      if (i > 0) begin
        lo_w[(i-1)/W][W-1-((i-1)%W)] = lo_bit;
        hi_w[(i-1)/W][W-1-((i-1)%W)] = hi_bit;
      end
      if (i < np*W) begin
        aw = (i/W == 0) ? a0 : a1;
        bw = (i/W == 0) ? b0 : b1;
        if (i % W == 0) st = 0;
        if (st == 0 && aw[W-1-(i%W)] && !bw[W-1-(i%W)]) st = 1;
        else if (st == 0 && !aw[W-1-(i%W)] && bw[W-1-(i%W)]) st = 2;
        start = (i % W == 0);
        a_bit = aw[W-1-(i%W)];
        b_bit = bw[W-1-(i%W)];
        rev_hi_in = 1'($urandom);
        rev_lo_in = 1'($urandom);
        #1;
        if (rev_a_out !== (st == 1 ? rev_hi_in : rev_lo_in) ||
            rev_b_out !== (st == 1 ? rev_lo_in : rev_hi_in))
          rev_bad[i/W]++;
      end else begin
        start = 1'b0; a_bit = 1'b0; b_bit = 1'b0;
      end
    end
    for (int p = 0; p < np; p++) begin
      aw = (p == 0) ? a0 : a1;
      bw = (p == 0) ? b0 : b1;
      chk(lo_w[p] == ((aw < bw) ? aw : bw), {"R5 R3 R4 min ", tag}, 32'(lo_w[p]), 32'((aw < bw) ? aw : bw));
      chk(hi_w[p] == ((aw < bw) ? bw : aw), {"R5 R3 R4 max ", tag}, 32'(hi_w[p]), 32'((aw < bw) ? bw : aw));
      chk(rev_bad[p] == 0, {"R6 R7 reverse ", tag}, 32'(rev_bad[p]), 32'd0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(lo_bit == 1'b0 && hi_bit == 1'b0, "R9 outputs in reset", {hi_bit, lo_bit}, 0);
    rev_hi_in = 1'b1; rev_lo_in = 1'b0; #1;
    chk(rev_a_out == 1'b0 && rev_b_out == 1'b1, "R7 reverse after reset", {rev_a_out, rev_b_out}, 2'b01);
  endtask

  task automatic t_equal_words;
    stream(8'hA5, 8'hA5, 8'h00, 8'h00, 1, "equal words");
    stream(8'hFF, 8'hFF, 8'h00, 8'h00, 1, "all ones");
  endtask

  task automatic t_equal_follow;
    @(negedge clk); start = 1'b1; a_bit = 1'b1; b_bit = 1'b1;
    @(negedge clk);
    chk(lo_bit == 1'b1 && hi_bit == 1'b1, "R2 equal bits copied", {hi_bit, lo_bit}, 2'b11);
    start = 1'b0; a_bit = 1'b0; b_bit = 1'b0;
  endtask

  task automatic t_directions;
    stream(8'h80, 8'h7F, 8'h00, 8'h00, 1, "msb A greater");
    stream(8'h3C, 8'h3D, 8'h00, 8'h00, 1, "lsb A less");
    stream(8'h10, 8'h0F, 8'h00, 8'h00, 1, "later bits oppose");
  endtask

  task automatic t_latency;
    @(negedge clk); start = 1'b1; a_bit = 1'b1; b_bit = 1'b0;
    #1;
    chk(hi_bit == 1'b0, "R8 no change before edge", hi_bit, 0);
    @(negedge clk);
    chk(hi_bit == 1'b1 && lo_bit == 1'b0, "R8 R3 one clock later", {hi_bit, lo_bit}, 2'b10);
    start = 1'b0; a_bit = 1'b0; b_bit = 1'b1;
    @(negedge clk);
    chk(hi_bit == 1'b0 && lo_bit == 1'b1, "R4 kept after decision", {hi_bit, lo_bit}, 2'b01);
    a_bit = 1'b0; b_bit = 1'b0;
  endtask

  task automatic t_back_to_back;
    stream(8'hC0, 8'h40, 8'h12, 8'h92, 2, "R1 restart gt then lt");
    stream(8'h01, 8'h80, 8'h77, 8'h77, 2, "R1 restart lt then eq");
  endtask

  task automatic t_mid_reset;
    @(negedge clk); start = 1'b1; a_bit = 1'b1; b_bit = 1'b0;
    @(negedge clk); start = 1'b0;
    rst_n = 1'b0; #1;
    chk(lo_bit == 1'b0 && hi_bit == 1'b0, "R9 async clear", {hi_bit, lo_bit}, 0);
    @(negedge clk); rst_n = 1'b1; a_bit = 1'b0; b_bit = 1'b1;
    rev_hi_in = 1'b1; rev_lo_in = 1'b0; #1;
    chk(rev_b_out == 1'b1 && rev_a_out == 1'b0, "R9 R6 fresh lt without start", {rev_a_out, rev_b_out}, 2'b01);
    @(negedge clk);
    chk(hi_bit == 1'b1 && lo_bit == 1'b0, "R9 fresh decision", {hi_bit, lo_bit}, 2'b10);
    a_bit = 1'b0; b_bit = 1'b0;
  endtask

  task automatic t_random;
    for (int n = 0; n < 20; n++)
      stream(W'($urandom), W'($urandom), W'($urandom), W'($urandom), 2, "random");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; a_bit = 1'b0; b_bit = 1'b0;
    rev_hi_in = 1'b0; rev_lo_in = 1'b0;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_equal_words();
    t_equal_follow();
    t_directions();
    t_latency();
    t_back_to_back();
    t_mid_reset();
    t_random();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule